// File: doc/BRIEF.md
# Programmable Chip-Select Wait-State Unit

This block decodes a 24-bit bus address against a bank of programmable select channels, eight by default. Each channel drives one active-low select line and sets the length of the bus cycle for its region. When a channel's strobe is active, the unit drives that channel's select low. It then returns a one-clock internal acknowledge after a programmed number of wait states, or after the external DTACK input is sampled low.

Each channel has one 16-bit control word. The word holds a region base, a region size, a wait code, a direction qualifier, a byte-lane qualifier and a strobe choice. The word is written through a simple register port. If an access breaks a channel's direction or lane limits and the watchdog enable is high, the unit reports a bus error after a fixed timeout. The highest-numbered channel acts as the boot channel and holds a usable setting straight out of hardware reset.

Top module: `csel_wait_unit`

## Requirements
- R1: A hardware reset (`rst` high at a clock edge) puts every channel except the highest-numbered one into the disabled state, so those selects stay high for any access. It also clears `ack` and `berr`.
- R2: After hardware reset, the boot channel (channel 7) covers 0x000000 to 0x7FFFFF. It is timed by the address strobe, allows reads only, permits both byte lanes and uses 6 wait states. A write in that region drives no select.
- R3: The control word layout is:
  - bit 15: strobe choice, 0 = address strobe, 1 = either data strobe.
  - bits 14:13: lane, 0 = word, 1 = low byte only, 2 = high byte only, 3 = channel disabled.
  - bits 12:11: direction, 0 or 3 = both, 1 = reads only, 2 = writes only.
  - bits 10:8: wait code.
  - bits 7:5: size code S, where 0..4 means 512 KB, 1, 2, 4 or 8 MB, and values above 4 act as 4.
  - bits 4:0: the base, compared with address bits 23:19. The lowest S bits are ignored in the comparison.
  A write with `reg_we` high loads word `reg_wdata` into channel `reg_sel` at the clock edge.
- R4: When several enabled channels match an address, only the lowest-numbered one may drive its select. At most one select is low at any time.
- R5: A select is low only while its channel's chosen strobe is active (`as_n` low, or `uds_n` or `lds_n` low). The select follows the inputs without a clock delay.
- R6: When the winning channel is limited to reads and the access is a write (`rnw` = 0), or it is limited to writes and the access is a read, no select is driven.
- R7: On a low-byte-only channel, an access with `uds_n` low is a violation. On a high-byte-only channel, an access with `lds_n` low is a violation. A violation drives no select.
- R8: For wait code W from 0 to 6, `ack` rises at clock edge 4+W when `fast_cycle` = 0, or 3+W when `fast_cycle` = 1. Edge 1 is the first edge that samples the winning channel's strobe active.
- R9: With wait code 7, `ack` rises at the first edge that is both no earlier than edge 4 (or 3 when fast) and samples `dtack_n` low. If `dtack_n` stays high, no `ack` is given.
- R10: On a violating access with `wd_en` = 1, `berr` rises at edge 65 and `ack` never rises. With `wd_en` = 0, neither output rises.
- R11: A `soft_rst` pulse abandons any cycle in progress and clears `ack` and `berr`. It leaves every control word unchanged.
- R12: `ack` and `berr` are single-clock pulses that are never high together, with at most one per strobe assertion. If the strobe is removed before the acknowledge edge, no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Cycle abort that keeps control words |
| fast_cycle | input | 1 | 1 = three-clock minimum cycle, 0 = four-clock |
| wd_en | input | 1 | Enables the bus-error timeout on violations |
| addr | input | 24 | Bus address |
| rnw | input | 1 | 1 = read, 0 = write |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| dtack_n | input | 1 | External transfer acknowledge, active low |
| reg_we | input | 1 | Control word write enable |
| reg_sel | input | 3 | Channel index for the write |
| reg_wdata | input | 16 | Control word data |
| cs_n | output | 8 | Select lines, active low, one per channel |
| ack | output | 1 | Internal acknowledge pulse |
| berr | output | 1 | Bus error pulse |

## Verification
A corrupted control word shows up in two places. The select pattern changes in the same cycle the address is applied, or the acknowledge moves away from edge 3+W or 4+W. Both effects are measurable within one bus cycle. A cycle timer stuck in a wrong state shows up as a missing, doubled or early acknowledge or bus error on the very next access. A wrong timeout length shifts the bus error away from edge 65.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int BASE_W      = 5;
    localparam int CTRL_W      = 16;
    localparam int WAIT_W      = 3;
    localparam int SIZE_W      = 3;
    localparam int MAX_SIZE    = 4;
    localparam int FAST_BASE   = 1;
    localparam int SLOW_BASE   = 2;
    localparam logic [WAIT_W-1:0] WAIT_DTACK = 3'd7;

    typedef enum logic [1:0] {
        DIR_BOTH = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2,
        DIR_ANY  = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        LANE_WORD = 2'd0,
        LANE_LOW  = 2'd1,
        LANE_HIGH = 2'd2,
        LANE_OFF  = 2'd3
    } lane_e;

    typedef struct packed {
        logic              strobe_ds;
        lane_e             lane;
        dir_e              dir;
        logic [WAIT_W-1:0] wait_code;
        logic [SIZE_W-1:0] size;
        logic [BASE_W-1:0] base;
    } csel_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_TMO,
        ST_DONE,
        ST_STALL
    } cyc_state_e;

    localparam csel_ctrl_t BOOT_CTRL = '{
        strobe_ds: 1'b0, lane: LANE_WORD, dir: DIR_RD,
        wait_code: 3'd6, size: 3'd4, base: '0
    };

    localparam csel_ctrl_t OFF_CTRL = '{
        strobe_ds: 1'b0, lane: LANE_OFF, dir: DIR_BOTH,
        wait_code: 3'd0, size: 3'd0, base: '0
    };

    // Region test: upper address bits against base, low bits masked by size
    function automatic logic region_hit(csel_ctrl_t c, logic [BASE_W-1:0] a_hi);
        logic [SIZE_W-1:0] sz;
        logic [BASE_W-1:0] care;
        sz   = (c.size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : c.size;
        care = {BASE_W{1'b1}} << sz;
        return ((a_hi ^ c.base) & care) == '0;
    endfunction

    // Direction or byte-lane breach of a restricted channel
    function automatic logic access_bad(csel_ctrl_t c, logic rnw, logic uds_n, logic lds_n);
        logic dir_bad;
        logic lane_bad;
        dir_bad  = (c.dir == DIR_RD && !rnw) || (c.dir == DIR_WR && rnw);
        lane_bad = (c.lane == LANE_LOW && !uds_n) || (c.lane == LANE_HIGH && !lds_n);
        return dir_bad || lane_bad;
    endfunction

    function automatic logic strobe_live(logic use_ds, logic as_n, logic uds_n, logic lds_n);
        return use_ds ? (!uds_n || !lds_n) : !as_n;
    endfunction

endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
    import csel_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [SEL_W-1:0]              sel,
    input  logic [CTRL_W-1:0]             wdata,
    output csel_ctrl_t [NUM_CH-1:0]       ctrl
);

    localparam int BOOT_CH = NUM_CH - 1;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam csel_ctrl_t RST_VAL = (i == BOOT_CH) ? BOOT_CTRL : OFF_CTRL;
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl[i] <= RST_VAL;
            end else if (we && sel == SEL_W'(i)) begin
                ctrl[i] <= csel_ctrl_t'(wdata);
            end
        end
    end

endmodule

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  csel_ctrl_t [NUM_CH-1:0] ctrl,
    input  logic [BASE_W-1:0]       a_hi,
    input  logic                    rnw,
    input  logic                    as_n,
    input  logic                    uds_n,
    input  logic                    lds_n,
    output logic [NUM_CH-1:0]       cs_n,
    output logic                    any_hit,
    output logic                    win_bad,
    output logic                    win_live,
    output logic                    win_ds,
    output logic [WAIT_W-1:0]       win_wait
);

    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] grant;
    csel_ctrl_t        win_ctrl;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign hit[i] = (ctrl[i].lane != LANE_OFF) && region_hit(ctrl[i], a_hi);
    end

    // Fixed priority: lowest channel index wins
    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        win_ctrl = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) begin
                win_ctrl = csel_ctrl_t'(win_ctrl | ctrl[i]);
            end
        end
    end

    assign any_hit  = |hit;
    assign win_bad  = access_bad(win_ctrl, rnw, uds_n, lds_n);
    assign win_live = strobe_live(win_ctrl.strobe_ds, as_n, uds_n, lds_n);
    assign win_ds   = win_ctrl.strobe_ds;
    assign win_wait = win_ctrl.wait_code;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cs
        assign cs_n[i] = !(grant[i] && !win_bad && win_live);
    end

endmodule

// File: rtl/csel_cycle_timer.sv
module csel_cycle_timer
    import csel_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              fast_cycle,
    input  logic              wd_en,
    input  logic              dtack_n,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              any_hit,
    input  logic              win_bad,
    input  logic              win_live,
    input  logic              win_ds,
    input  logic [WAIT_W-1:0] win_wait,
    output logic              ack,
    output logic              berr
);

    localparam int Q_W = $clog2(TIMEOUT_CYC + 8);
    localparam logic [Q_W-1:0] TMO_TGT = Q_W'(TIMEOUT_CYC - 1);

    cyc_state_e     st;
    logic [Q_W-1:0] q;
    logic [Q_W-1:0] tgt;
    logic [Q_W-1:0] base_len;
    logic           dt_mode;
    logic           ds_cap;
    logic           cap_live;
    logic           q_sat;

    assign base_len = fast_cycle ? Q_W'(FAST_BASE) : Q_W'(SLOW_BASE);
    assign cap_live = strobe_live(ds_cap, as_n, uds_n, lds_n);
    assign q_sat    = (q == {Q_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            st      <= ST_IDLE;
            q       <= '0;
            tgt     <= '0;
            dt_mode <= 1'b0;
            ds_cap  <= 1'b0;
            ack     <= 1'b0;
            berr    <= 1'b0;
        end else begin
            ack  <= 1'b0;
            berr <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (any_hit && win_live) begin
                        ds_cap  <= win_ds;
                        q       <= '0;
                        dt_mode <= (win_wait == WAIT_DTACK);
                        if (!win_bad) begin
                            st  <= ST_COUNT;
                            tgt <= (win_wait == WAIT_DTACK) ? base_len
                                                            : base_len + Q_W'(win_wait);
                        end else if (wd_en) begin
                            st  <= ST_TMO;
                            tgt <= TMO_TGT;
                        end else begin
                            st  <= ST_STALL;
                        end
                    end
                end
                ST_COUNT: begin
                    if (!cap_live) begin
                        st <= ST_IDLE;
                    end else begin
                        if (!q_sat) q <= q + 1'b1;
                        if (dt_mode ? (q >= tgt && !dtack_n) : (q == tgt)) begin
                            ack <= 1'b1;
                            st  <= ST_DONE;
                        end
                    end
                end
                ST_TMO: begin
                    if (!cap_live) begin
                        st <= ST_IDLE;
                    end else begin
                        q <= q + 1'b1;
                        if (q == tgt) begin
                            berr <= 1'b1;
                            st   <= ST_DONE;
                        end
                    end
                end
                ST_DONE, ST_STALL: begin
                    if (!cap_live) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/csel_wait_unit.sv
module csel_wait_unit
    import csel_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int ADDR_W      = 24,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        soft_rst,
    input  logic                        fast_cycle,
    input  logic                        wd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        rnw,
    input  logic                        as_n,
    input  logic                        uds_n,
    input  logic                        lds_n,
    input  logic                        dtack_n,
    input  logic                        reg_we,
    input  logic [$clog2(NUM_CH)-1:0]   reg_sel,
    input  logic [CTRL_W-1:0]           reg_wdata,
    output logic [NUM_CH-1:0]           cs_n,
    output logic                        ack,
    output logic                        berr
);

    localparam int SEL_W = $clog2(NUM_CH);

    csel_ctrl_t [NUM_CH-1:0] ctrl;
    logic                    any_hit;
    logic                    win_bad;
    logic                    win_live;
    logic                    win_ds;
    logic [WAIT_W-1:0]       win_wait;

    csel_regfile #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    csel_decode #(.NUM_CH(NUM_CH)) u_dec (
        .ctrl     (ctrl),
        .a_hi     (addr[ADDR_W-1 -: BASE_W]),
        .rnw      (rnw),
        .as_n     (as_n),
        .uds_n    (uds_n),
        .lds_n    (lds_n),
        .cs_n     (cs_n),
        .any_hit  (any_hit),
        .win_bad  (win_bad),
        .win_live (win_live),
        .win_ds   (win_ds),
        .win_wait (win_wait)
    );

    csel_cycle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .fast_cycle (fast_cycle),
        .wd_en      (wd_en),
        .dtack_n    (dtack_n),
        .as_n       (as_n),
        .uds_n      (uds_n),
        .lds_n      (lds_n),
        .any_hit    (any_hit),
        .win_bad    (win_bad),
        .win_live   (win_live),
        .win_ds     (win_ds),
        .win_wait   (win_wait),
        .ack        (ack),
        .berr       (berr)
    );

endmodule

// File: rtl/csel_wait_unit_chk.sv
module csel_wait_unit_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic [NUM_CH-1:0] cs_n,
    input logic              ack,
    input logic              berr,
    input logic              any_hit,
    input logic              win_bad
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)); // R4

    AST_BAD_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        (any_hit && win_bad) |-> (&cs_n)); // R6

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R12

    AST_BERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        berr |=> !berr); // R12

    AST_ACK_BERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ack && berr)); // R12

    AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!ack && !berr)); // R11

    AST_BOOT_OTHERS_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&cs_n[NUM_CH-2:0])); // R1

endmodule

bind csel_wait_unit csel_wait_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .cs_n     (cs_n),
    .ack      (ack),
    .berr     (berr),
    .any_hit  (any_hit),
    .win_bad  (win_bad)
);

// File: tb/csel_wait_unit_tb.sv
module csel_wait_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        fast_cycle = 1'b0;
    logic        wd_en = 1'b0;
    logic [23:0] addr = '0;
    logic        rnw = 1'b1;
    logic        as_n = 1'b1;
    logic        uds_n = 1'b1;
    logic        lds_n = 1'b1;
    logic        dtack_n = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [7:0]  cs_n;
    logic        ack;
    logic        berr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    csel_wait_unit u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .fast_cycle(fast_cycle),
        .wd_en(wd_en), .addr(addr), .rnw(rnw), .as_n(as_n), .uds_n(uds_n),
        .lds_n(lds_n), .dtack_n(dtack_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cs_n(cs_n), .ack(ack), .berr(berr)
    );

    typedef struct packed {
        logic [23:0] a;
        logic        rd;
        logic        u_n;
        logic        l_n;
        logic        s_n;
        logic [7:0]  cs;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{24'h180000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFE},  // R3 ch0 read
        '{24'h100000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFE},  // R4 ch0 over ch1, ch7
        '{24'h050000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFD},  // R4 ch1 over ch7
        '{24'h050000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},  // R6 read on write-only winner
        '{24'h300000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7F},  // R2 boot read
        '{24'h300000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},  // R2 boot write refused
        '{24'h840000, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFB},  // R5 data-strobe channel
        '{24'h840000, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF},  // R5 no data strobe
        '{24'h840000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},  // R7 word on low-byte channel
        '{24'h900000, 1'b1, 1'b0, 1'b1, 1'b0, 8'hF7},  // R7 high byte allowed
        '{24'h900000, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF},  // R7 low byte refused
        '{24'hB80000, 1'b1, 1'b0, 1'b1, 1'b0, 8'hF7},  // R3 4 MB extent
        '{24'hC00000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},  // R3 unmapped
        '{24'h880000, 1'b1, 1'b0, 1'b1, 1'b0, 8'hF7},  // R3 past 512 KB edge
        '{24'h180000, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF}   // R5 address strobe off
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [2:0] ch, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = ch; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Combinational select check, strobes never seen by a clock edge
    task automatic probe(input logic [23:0] a, input logic rd, input logic u_n,
                         input logic l_n, input logic s_n, output logic [7:0] got);
        @(negedge clk);
        addr = a; rnw = rd; uds_n = u_n; lds_n = l_n; as_n = s_n;
        #2 got = cs_n;
        #2 as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    endtask

    // Edge numbers count from the first posedge that sees the strobe
    task automatic run_cycle(input logic [23:0] a, input logic rd, input logic u_n,
                             input logic l_n, input int dt_edge, input int limit,
                             output int ack_at, output int berr_at, output int n_ack);
        @(negedge clk);
        addr = a; rnw = rd; as_n = 1'b0; uds_n = u_n; lds_n = l_n;
        dtack_n = (dt_edge == 0) ? 1'b0 : 1'b1;
        ack_at = 0; berr_at = 0; n_ack = 0;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            if (ack) begin
                n_ack++;
                if (ack_at == 0) ack_at = n;
            end
            if (berr && berr_at == 0) berr_at = n;
            if (dt_edge != 0 && n >= dt_edge) dtack_n = 1'b0;
        end
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; dtack_n = 1'b1;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            if (ack) n_ack++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] got;
        int a_at, b_at, na;

        hard_reset();

        // R1 reset state
        chk("R1 ack after reset", ack, 0);
        chk("R1 berr after reset", berr, 0);
        probe(24'h100000, 1'b1, 1'b0, 1'b0, 1'b0, got);
        chk("R1 ch0 disabled, boot answers", got, 8'h7F);
        probe(24'h300000, 1'b0, 1'b0, 1'b0, 1'b0, got);
        chk("R2 boot write no select", got, 8'hFF);

        // R2 R8 boot timing, 6 waits, normal cycle
        run_cycle(24'h300000, 1'b1, 1'b0, 1'b0, 0, 14, a_at, b_at, na);
        chk("R2 boot ack edge", a_at, 10);

        // Program channels: R3 layout
        wr_ctrl(3'd0, 16'h0222);
        wr_ctrl(3'd1, 16'h1040);
        wr_ctrl(3'd2, 16'hA710);
        wr_ctrl(3'd3, 16'h4974);

        for (int i = 0; i < NVEC; i++) begin
            probe(VECS[i].a, VECS[i].rd, VECS[i].u_n, VECS[i].l_n, VECS[i].s_n, got);
            chk($sformatf("R3-R7 table row %0d", i), got, VECS[i].cs);
        end

        // R8 counted wait states
        run_cycle(24'h180000, 1'b1, 1'b0, 1'b0, 0, 12, a_at, b_at, na);
        chk("R8 ch0 normal ack edge", a_at, 6);
        chk("R12 single ack", na, 1);
        fast_cycle = 1'b1;
        run_cycle(24'h180000, 1'b1, 1'b0, 1'b0, 0, 12, a_at, b_at, na);
        chk("R8 ch0 fast ack edge", a_at, 5);
        run_cycle(24'h050000, 1'b0, 1'b0, 1'b0, 0, 12, a_at, b_at, na);
        chk("R8 ch1 fast zero-wait", a_at, 3);
        fast_cycle = 1'b0;
        run_cycle(24'h050000, 1'b0, 1'b0, 1'b0, 0, 12, a_at, b_at, na);
        chk("R8 ch1 normal zero-wait", a_at, 4);
        run_cycle(24'h900000, 1'b1, 1'b0, 1'b1, 0, 12, a_at, b_at, na);
        chk("R8 ch3 one wait", a_at, 5);

        // R9 DTACK-timed channel
        run_cycle(24'h840000, 1'b1, 1'b1, 1'b0, 0, 12, a_at, b_at, na);
        chk("R9 dtack low, normal", a_at, 4);
        fast_cycle = 1'b1;
        run_cycle(24'h840000, 1'b1, 1'b1, 1'b0, 0, 12, a_at, b_at, na);
        chk("R9 dtack low, fast", a_at, 3);
        fast_cycle = 1'b0;
        run_cycle(24'h840000, 1'b1, 1'b1, 1'b0, 7, 14, a_at, b_at, na);
        chk("R9 late dtack", a_at, 8);
        run_cycle(24'h840000, 1'b1, 1'b1, 1'b0, 99, 20, a_at, b_at, na);
        chk("R9 no dtack no ack", na, 0);

        // R10 violation timeout
        wd_en = 1'b1;
        run_cycle(24'h300000, 1'b0, 1'b0, 1'b0, 0, 70, a_at, b_at, na);
        chk("R10 berr edge", b_at, 65);
        chk("R10 no ack on violation", na, 0);
        wd_en = 1'b0;
        run_cycle(24'h300000, 1'b0, 1'b0, 1'b0, 0, 70, a_at, b_at, na);
        chk("R10 no berr without wd_en", b_at, 0);

        // R12 strobe removed early
        run_cycle(24'h180000, 1'b1, 1'b0, 1'b0, 0, 2, a_at, b_at, na);
        chk("R12 aborted cycle no ack", na, 0);

        // R11 soft reset keeps control words
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        probe(24'h180000, 1'b1, 1'b0, 1'b0, 1'b0, got);
        chk("R11 ch0 kept", got, 8'hFE);
        run_cycle(24'h180000, 1'b1, 1'b0, 1'b0, 0, 12, a_at, b_at, na);
        chk("R11 ch0 timing kept", a_at, 6);
        wr_ctrl(3'd7, 16'h6000);
        probe(24'h300000, 1'b1, 1'b0, 1'b0, 1'b0, got);
        chk("R3 boot channel disabled by write", got, 8'hFF);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        probe(24'h300000, 1'b1, 1'b0, 1'b0, 1'b0, got);
        chk("R11 disabled boot stays after soft reset", got, 8'hFF);

        // R1 R2 hard reset restores defaults
        hard_reset();
        probe(24'h300000, 1'b1, 1'b0, 1'b0, 1'b0, got);
        chk("R2 boot restored", got, 8'h7F);
        probe(24'h180000, 1'b1, 1'b0, 1'b0, 1'b0, got);
        chk("R1 ch0 cleared", got, 8'h7F);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule